// File: doc/BRIEF.md
# Power-Up Interface Mode Selector

This block decides, once after supply comes up, which of two serial personalities a secure memory presents. One is a smart-card style asynchronous half-duplex link. The other is a synchronous two-wire link. The block runs on the device clock pin. It watches the reset pin from the first clock edge after supply becomes valid.

If reset is already high at that first edge, the two-wire mode is taken, because reset is pulled up inside the device. If reset starts low, the block counts clock edges while it stays low. When reset rises, the count picks the mode. A count of at least 400 edges gives the asynchronous mode, and that choice fires a one-cycle trigger to the answer-to-reset transmitter. A shorter count falls back to the two-wire mode.

Whichever mode is chosen stays latched until supply is removed. In the two-wire mode a command-ready flag opens once five further clock pulses have been received. While the choice is pending, the data pin is held in receive. The supply-valid input is an asynchronous active-low reset that clears the latch and both counters.

Top module: `linksel_top`

## Requirements
- R1: While supplyOk is low, modeOneHot is 2'b00, atrStart is 0, cmdReady is 0 and rxHold is 1. This holds immediately, without waiting for a clock edge.
- R2: If rstPin is high at the first rising clock edge after supplyOk rises, that edge latches the two-wire mode (modeOneHot = 2'b01, bit 0 = two-wire).
- R3: If rstPin is sampled low on N consecutive rising edges from the first edge on, and is then sampled high, that edge latches the asynchronous mode (modeOneHot = 2'b10, bit 1 = asynchronous) when N >= 400. It latches the two-wire mode when N < 400.
- R4: The low-reset edge count saturates and does not wrap, so any N of 400 or more, including very long holds, selects the asynchronous mode.
- R5: atrStart is high for exactly one cycle, directly after the edge that latches the asynchronous mode, and is never high at any other time.
- R6: Once the asynchronous mode is latched, later rstPin activity changes neither modeOneHot nor atrStart until supplyOk falls.
- R7: Once the two-wire mode is latched, later rstPin activity, including a low hold of 400 edges or more, does not change modeOneHot.
- R8: cmdReady rises after the fifth rising edge that follows the edge latching the two-wire mode, then stays high. It is never high in the asynchronous mode.
- R9: rxHold is 1 while no mode is latched and falls to 0 at the edge that latches a mode.
- R10: Dropping supplyOk at any time clears the mode and both counters, so the next power-up is decided afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock pin, used as the block clock |
| supplyOk | input | 1 | Supply valid; low is an asynchronous clear |
| rstPin | input | 1 | External reset pin level |
| modeOneHot | output | 2 | Latched mode: bit 0 two-wire, bit 1 asynchronous |
| atrStart | output | 1 | One-cycle trigger for the answer-to-reset transmitter |
| cmdReady | output | 1 | Two-wire decoder may accept a command |
| rxHold | output | 1 | Keep the data pin in receive while undecided |

## Verification
The assertions assume that supplyOk is the only reset. They also assume that rstPin is a clean level that never changes on the active clock edge, so each edge sees one settled value. The bench changes rstPin and supplyOk only on falling edges of the clock and reads the outputs there. Edge counts are therefore exact, and the boundary holds of 399 and 400 low edges land on known edges. Supply drops are the one stimulus that the bench also applies between edges, because the clear is meant to act at once.

// File: rtl/linksel_pkg.sv
package linksel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COLD  = 2'd1,
    ST_SYNC  = 2'd2,
    ST_ASYNC = 2'd3
  } selState_t;

  typedef struct packed {
    logic coldInc;
    logic gateInc;
  } selStrobe_t;
endpackage

// File: rtl/linksel_count.sv
module linksel_count
  import linksel_pkg::*;
#(
  parameter int COLD_CYCLES = 400,
  parameter int GATE_PULSES = 5
) (
  input  logic       clk,
  input  logic       supplyOk,
  input  selStrobe_t strobe,
  output logic       coldDone,
  output logic       gateDone
);
  localparam int COLD_W = $clog2(COLD_CYCLES + 1);
  localparam int GATE_W = $clog2(GATE_PULSES + 1);
  localparam logic [COLD_W-1:0] COLD_MAX = COLD_W'(COLD_CYCLES);
  localparam logic [GATE_W-1:0] GATE_MAX = GATE_W'(GATE_PULSES);

  logic [COLD_W-1:0] coldCnt;
  logic [GATE_W-1:0] gateCnt;

  // saturating count of edges seen with reset low
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) coldCnt <= '0;
    else if (strobe.coldInc && coldCnt != COLD_MAX) coldCnt <= coldCnt + 1'b1;
  end

  // saturating count of pulses after the two-wire latch
  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) gateCnt <= '0;
    else if (strobe.gateInc && gateCnt != GATE_MAX) gateCnt <= gateCnt + 1'b1;
  end

  assign coldDone = (coldCnt == COLD_MAX);
  assign gateDone = (gateCnt == GATE_MAX);
endmodule

// File: rtl/linksel_fsm.sv
module linksel_fsm
  import linksel_pkg::*;
(
  input  logic       clk,
  input  logic       supplyOk,
  input  logic       rstPin,
  input  logic       coldDone,
  input  logic       gateDone,
  output selStrobe_t strobe,
  output logic [1:0] modeOneHot,
  output logic       atrStart,
  output logic       cmdReady,
  output logic       rxHold
);
  selState_t state, stateNext;
  logic      atrNext;

  always_comb begin
    stateNext      = state;
    atrNext        = 1'b0;
    strobe.coldInc = 1'b0;
    strobe.gateInc = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rstPin) stateNext = ST_SYNC;
        else begin
          stateNext      = ST_COLD;
          strobe.coldInc = 1'b1;
        end
      end
      ST_COLD: begin
        if (!rstPin) strobe.coldInc = 1'b1;
        else if (coldDone) begin
          stateNext = ST_ASYNC;
          atrNext   = 1'b1;
        end else stateNext = ST_SYNC;
      end
      ST_SYNC:  strobe.gateInc = 1'b1;
      ST_ASYNC: ;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) begin
      state    <= ST_IDLE;
      atrStart <= 1'b0;
    end else begin
      state    <= stateNext;
      atrStart <= atrNext;
    end
  end

  assign modeOneHot = {state == ST_ASYNC, state == ST_SYNC};
  assign cmdReady   = (state == ST_SYNC) && gateDone;
  assign rxHold     = (state == ST_IDLE) || (state == ST_COLD);
endmodule

// File: rtl/linksel_top.sv
module linksel_top
  import linksel_pkg::*;
#(
  parameter int COLD_CYCLES = 400,
  parameter int GATE_PULSES = 5
) (
  input  logic       clk,
  input  logic       supplyOk,
  input  logic       rstPin,
  output logic [1:0] modeOneHot,
  output logic       atrStart,
  output logic       cmdReady,
  output logic       rxHold
);
  selStrobe_t strobe;
  logic       coldDone;
  logic       gateDone;

  linksel_count #(
    .COLD_CYCLES(COLD_CYCLES),
    .GATE_PULSES(GATE_PULSES)
  ) u_count (
    .clk(clk),
    .supplyOk(supplyOk),
    .strobe(strobe),
    .coldDone(coldDone),
    .gateDone(gateDone)
  );

  linksel_fsm u_fsm (
    .clk(clk),
    .supplyOk(supplyOk),
    .rstPin(rstPin),
    .coldDone(coldDone),
    .gateDone(gateDone),
    .strobe(strobe),
    .modeOneHot(modeOneHot),
    .atrStart(atrStart),
    .cmdReady(cmdReady),
    .rxHold(rxHold)
  );
endmodule

// File: rtl/linksel_checker.sv
module linksel_checker (
  input logic       clk,
  input logic       supplyOk,
  input logic [1:0] modeOneHot,
  input logic       atrStart,
  input logic       cmdReady,
  input logic       rxHold
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!supplyOk)
    $onehot0(modeOneHot));

  p_async_lock_r6: assert property (@(posedge clk) disable iff (!supplyOk)
    modeOneHot[1] |=> modeOneHot[1]);

  p_sync_lock_r7: assert property (@(posedge clk) disable iff (!supplyOk)
    modeOneHot[0] |=> modeOneHot[0]);

  p_atr_single_r5: assert property (@(posedge clk) disable iff (!supplyOk)
    atrStart |=> !atrStart);

  p_atr_on_latch_r5: assert property (@(posedge clk) disable iff (!supplyOk)
    atrStart |-> (modeOneHot == 2'b10) && $past(rxHold));

  p_cmd_sync_r8: assert property (@(posedge clk) disable iff (!supplyOk)
    cmdReady |-> modeOneHot[0]);

  p_cmd_stays_r8: assert property (@(posedge clk) disable iff (!supplyOk)
    cmdReady |=> cmdReady);

  p_rxhold_fall_r9: assert property (@(posedge clk) disable iff (!supplyOk)
    $fell(rxHold) |-> (modeOneHot != 2'b00));
endmodule

bind linksel_top linksel_checker u_chk (
  .clk(clk),
  .supplyOk(supplyOk),
  .modeOneHot(modeOneHot),
  .atrStart(atrStart),
  .cmdReady(cmdReady),
  .rxHold(rxHold)
);

// File: tb/sim_linksel_top.sv
`timescale 1ns/1ps
module sim_linksel_top;
  logic       clk = 1'b0;
  logic       supplyOk = 1'b0;
  logic       rstPin = 1'b0;
  logic [1:0] modeOneHot;
  logic       atrStart;
  logic       cmdReady;
  logic       rxHold;

  int nChecks = 0;
  int nFails  = 0;
  bit runDone = 1'b0;

  always #2.5 clk = ~clk;

  linksel_top u0 (
    .clk(clk),
    .supplyOk(supplyOk),
    .rstPin(rstPin),
    .modeOneHot(modeOneHot),
    .atrStart(atrStart),
    .cmdReady(cmdReady),
    .rxHold(rxHold)
  );

  localparam int VEC_N = 7;
  localparam int lowTab[VEC_N] = '{0, 1, 5, 399, 400, 401, 900};
  localparam logic [1:0] expTab[VEC_N] = '{2'b01, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // power cycle, hold reset low for lowEdges edges, then raise it;
  // returns at the falling edge right after the deciding edge
  task automatic powerUp(input int lowEdges);
    @(negedge clk);
    supplyOk = 1'b0;
    rstPin   = 1'b0;
    @(negedge clk);
    supplyOk = 1'b1;
    rstPin   = (lowEdges == 0);
    repeat (lowEdges) @(negedge clk);
    rstPin = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int atrSeen;
    // R1: reset state
    #12;
    chk(modeOneHot == 2'b00, "R1 mode", modeOneHot, 0);
    chk(!atrStart && !cmdReady, "R1 atr/cmd", {atrStart, cmdReady}, 0);
    chk(rxHold == 1'b1, "R1 rxHold", rxHold, 1);

    for (int i = 0; i < VEC_N; i++) begin
      powerUp(lowTab[i]);
      // R2 (no low edges), R3 boundary, R4 long hold
      chk(modeOneHot == expTab[i], "R2/R3/R4 mode", modeOneHot, expTab[i]);
      chk(rxHold == 1'b0, "R9 rxHold after latch", rxHold, 0);
      chk(atrStart == (expTab[i] == 2'b10), "R5 atr pulse", atrStart, expTab[i] == 2'b10);
      @(negedge clk);
      chk(atrStart == 1'b0, "R5 atr one cycle", atrStart, 0);
      repeat (3) @(negedge clk);
      chk(cmdReady == 1'b0, "R8 cmd before fifth", cmdReady, 0);
      @(negedge clk);
      chk(cmdReady == (expTab[i] == 2'b01), "R8 cmd at fifth", cmdReady, expTab[i] == 2'b01);
      repeat (3) @(negedge clk);
      chk(cmdReady == (expTab[i] == 2'b01), "R8 cmd holds", cmdReady, expTab[i] == 2'b01);
    end

    // R9: undecided while reset held low
    @(negedge clk);
    supplyOk = 1'b0;
    rstPin   = 1'b0;
    @(negedge clk);
    supplyOk = 1'b1;
    repeat (20) @(negedge clk);
    chk(rxHold == 1'b1 && modeOneHot == 2'b00, "R9 pending", {rxHold, modeOneHot}, 4);

    // R6: async lock against later reset activity
    powerUp(400);
    atrSeen = 0;
    rstPin = 1'b0;
    for (int k = 0; k < 450; k++) begin
      @(negedge clk);
      if (atrStart) atrSeen++;
    end
    rstPin = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (atrStart) atrSeen++;
    end
    chk(modeOneHot == 2'b10, "R6 mode locked", modeOneHot, 2);
    chk(atrSeen == 0, "R6 no second atr", atrSeen, 0);

    // R7: two-wire latch against a later cold sequence
    powerUp(0);
    rstPin = 1'b0;
    repeat (450) @(negedge clk);
    rstPin = 1'b1;
    repeat (5) @(negedge clk);
    chk(modeOneHot == 2'b01, "R7 mode locked", modeOneHot, 1);
    chk(cmdReady == 1'b1, "R7 cmd kept", cmdReady, 1);

    // R10: supply drop between edges clears at once, next power-up fresh
    #1;
    supplyOk = 1'b0;
    #0.5;
    chk(modeOneHot == 2'b00 && !cmdReady, "R10 clear", {modeOneHot, cmdReady}, 0);
    powerUp(400);
    chk(modeOneHot == 2'b10 && atrStart, "R10 fresh decide", {modeOneHot, atrStart}, 5);

    runDone = 1'b1;
    summary();
  end

  initial begin
    #500000;
    if (!runDone) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end
endmodule